// File: doc/BRIEF.md
# Two-Stage Split-Carry Wide Adder

This block adds two wide unsigned operands when the clock period is shorter than a full-width carry ripple. The carry chain is cut at the midpoint. In the first cycle the low halves are summed, and that sum and its carry-out are registered. The high halves of both operands are registered in the same cycle. In the second cycle the registered high halves are added together with the registered low carry. That high result is then joined with the low sum, which has been held one more cycle, so both halves belong to the same operand pair.

The upstream logic presents an operand pair with a one-cycle valid strobe. It may do so every clock. Exactly two clocks later the full sum, its carry-out and a valid strobe appear. Between results, the outputs hold the last value produced.

Top module: `split_wide_adder`

## Requirements
- R1: When `res_vld` is high, `{res_cout, res_sum}` equals the full 101-bit sum of the 100-bit operands `op_a` and `op_b` of the pair that was strobed.
- R2: `res_vld` is high in the cycle exactly two rising edges after a cycle with `op_vld` high, and low two edges after a cycle with `op_vld` low.
- R3: A new operand pair is accepted on every clock. Back-to-back pairs each produce their own correct result in consecutive cycles, with no mixing of halves between pairs.
- R4: A carry out of bit 49 (the top of the low half) is added into bit 50 of the result. For example, 0x3_FFFF_FFFF_FFFF + 1 gives 2^50 with `res_cout` = 0.
- R5: A carry out of bit 99 appears on `res_cout`. For example, all-ones + 1 gives `res_sum` = 0 with `res_cout` = 1.
- R6: A synchronous active-high `rst` clears `res_sum`, `res_cout` and `res_vld` to zero on the next rising edge, and discards any pair in flight.
- R7: Operand values presented while `op_vld` is low have no effect. `res_sum` and `res_cout` keep their last result while `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operand pair strobe |
| op_a | input | 100 | First operand |
| op_b | input | 100 | Second operand |
| res_sum | output | 100 | Sum, low 100 bits |
| res_cout | output | 1 | Carry out of bit 99 |
| res_vld | output | 1 | Result strobe, two clocks after `op_vld` |

## Verification
The hardest case to produce is two different pairs in adjacent pipeline stages, where only one of them generates a low-half carry. A single timing slip would then join the wrong high and low halves and still look like a plausible number. The stimulus streams the vector table with no gaps. Vectors with a carry out of bit 49 are placed next to vectors without one, so a misaligned carry or low sum shows up as a wrong bit 50 or a wrong low half. A reset asserted while a pair is in flight, and idle cycles with garbage operands, probe the discard and hold behaviour.

// File: rtl/split_add_pkg.sv
package split_add_pkg;
  localparam int DEF_SUM_W = 100;
  localparam int DEF_LO_W  = DEF_SUM_W / 2;
endpackage

// File: rtl/split_add_lo.sv
module split_add_lo #(
  parameter int SUM_W = split_add_pkg::DEF_SUM_W,
  parameter int LO_W  = split_add_pkg::DEF_LO_W,
  localparam int HI_W = SUM_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [SUM_W-1:0] in_a,
  input  logic [SUM_W-1:0] in_b,
  output logic             s1_vld,
  output logic [LO_W-1:0]  s1_lo_sum,
  output logic             s1_carry,
  output logic [HI_W-1:0]  s1_a_hi,
  output logic [HI_W-1:0]  s1_b_hi
);
  function automatic logic [LO_W:0] lo_add(input logic [LO_W-1:0] x, input logic [LO_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  logic [LO_W:0] lo_full;
  assign lo_full = lo_add(in_a[LO_W-1:0], in_b[LO_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      s1_lo_sum <= '0;
      s1_carry  <= 1'b0;
      s1_a_hi   <= '0;
      s1_b_hi   <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_lo_sum <= lo_full[LO_W-1:0];
        s1_carry  <= lo_full[LO_W];
        s1_a_hi   <= in_a[SUM_W-1:LO_W];
        s1_b_hi   <= in_b[SUM_W-1:LO_W];
      end
    end
  end
endmodule

// File: rtl/split_add_hi.sv
module split_add_hi #(
  parameter int SUM_W = split_add_pkg::DEF_SUM_W,
  parameter int LO_W  = split_add_pkg::DEF_LO_W,
  localparam int HI_W = SUM_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_vld,
  input  logic [LO_W-1:0]  s1_lo_sum,
  input  logic             s1_carry,
  input  logic [HI_W-1:0]  s1_a_hi,
  input  logic [HI_W-1:0]  s1_b_hi,
  output logic             s2_vld,
  output logic [SUM_W-1:0] s2_sum,
  output logic             s2_cout
);
  function automatic logic [HI_W:0] hi_add(input logic [HI_W-1:0] x, input logic [HI_W-1:0] y,
                                           input logic cin);
    return {1'b0, x} + {1'b0, y} + {{HI_W{1'b0}}, cin};
  endfunction

  logic [HI_W:0] hi_full;
  assign hi_full = hi_add(s1_a_hi, s1_b_hi, s1_carry);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_sum  <= '0;
      s2_cout <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_sum  <= {hi_full[HI_W-1:0], s1_lo_sum};
        s2_cout <= hi_full[HI_W];
      end
    end
  end
endmodule

// File: rtl/split_wide_adder.sv
module split_wide_adder #(
  parameter int SUM_W = split_add_pkg::DEF_SUM_W,
  parameter int LO_W  = split_add_pkg::DEF_LO_W,
  localparam int HI_W = SUM_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_vld,
  input  logic [SUM_W-1:0] op_a,
  input  logic [SUM_W-1:0] op_b,
  output logic [SUM_W-1:0] res_sum,
  output logic             res_cout,
  output logic             res_vld
);
  // Internal events brought out by name for the checker
  logic            s1_vld;
  logic [LO_W-1:0] s1_lo_sum;
  logic            s1_carry;
  logic [HI_W-1:0] s1_a_hi;
  logic [HI_W-1:0] s1_b_hi;

  split_add_lo #(.SUM_W(SUM_W), .LO_W(LO_W)) i_lo (
    .clk(clk), .rst(rst), .in_vld(op_vld), .in_a(op_a), .in_b(op_b),
    .s1_vld(s1_vld), .s1_lo_sum(s1_lo_sum), .s1_carry(s1_carry),
    .s1_a_hi(s1_a_hi), .s1_b_hi(s1_b_hi)
  );

  split_add_hi #(.SUM_W(SUM_W), .LO_W(LO_W)) i_hi (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_lo_sum(s1_lo_sum),
    .s1_carry(s1_carry), .s1_a_hi(s1_a_hi), .s1_b_hi(s1_b_hi),
    .s2_vld(res_vld), .s2_sum(res_sum), .s2_cout(res_cout)
  );
endmodule

// File: rtl/split_wide_adder_chk.sv
module split_wide_adder_chk #(
  parameter int SUM_W = 100,
  parameter int LO_W  = 50
) (
  input logic             clk,
  input logic             rst,
  input logic             op_vld,
  input logic [SUM_W-1:0] op_a,
  input logic [SUM_W-1:0] op_b,
  input logic [SUM_W-1:0] res_sum,
  input logic             res_cout,
  input logic             res_vld,
  input logic             s1_vld,
  input logic             s1_carry
);
  logic [SUM_W:0] ref_full;
  logic [LO_W:0]  ref_lo;
  assign ref_full = {1'b0, op_a} + {1'b0, op_b};
  assign ref_lo   = {1'b0, op_a[LO_W-1:0]} + {1'b0, op_b[LO_W-1:0]};

  // R1 / R3 / R5
  a_r1_full_sum: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ({res_cout, res_sum} == $past(ref_full, 2)));
  // R2
  a_r2_stage1_follow: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> s1_vld);
  a_r2_stage2_follow: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> res_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |=> !res_vld);
  // R4
  a_r4_mid_carry: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> (s1_carry == $past(ref_lo[LO_W])));
  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld && !$past(rst)) |=> ($stable(res_sum) && $stable(res_cout)));
  // R6
  a_r6_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!res_vld && !res_cout && (res_sum == '0)));
endmodule

bind split_wide_adder split_wide_adder_chk #(.SUM_W(SUM_W), .LO_W(LO_W)) i_chk (
  .clk(clk), .rst(rst), .op_vld(op_vld), .op_a(op_a), .op_b(op_b),
  .res_sum(res_sum), .res_cout(res_cout), .res_vld(res_vld),
  .s1_vld(s1_vld), .s1_carry(s1_carry)
);

// File: tb/test_split_wide_adder.sv
module test_split_wide_adder;
  localparam int W = 100;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_vld = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] res_sum;
  logic         res_cout;
  logic         res_vld;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  localparam logic [W-1:0] VA [N] = '{
    {W{1'b0}}, 100'd1, 100'h3_FFFF_FFFF_FFFF, {W{1'b1}},
    {W{1'b1}}, {25{4'h5}}, {25{4'h9}}, {1'b1, {(W-1){1'b0}}}
  };
  localparam logic [W-1:0] VB [N] = '{
    {W{1'b0}}, 100'd1, 100'd1, 100'd1,
    {W{1'b1}}, {25{4'hA}}, {25{4'h7}}, {1'b1, {(W-1){1'b0}}}
  };

  split_wide_adder i_split_wide_adder (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_a(op_a), .op_b(op_b),
    .res_sum(res_sum), .res_cout(res_cout), .res_vld(res_vld)
  );

  always #10 clk = ~clk;

  // Bit-serial reference sum, independent of the design's split
  function automatic logic [W:0] ripple(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] r;
    logic c;
    c = 1'b0;
    for (int k = 0; k < W; k++) begin
      r[k] = x[k] ^ y[k] ^ c;
      c = (x[k] & y[k]) | (x[k] & c) | (y[k] & c);
    end
    r[W] = c;
    return r;
  endfunction

  task automatic check_res(input string tag, input logic [W:0] exp_v, input logic exp_vld);
    total++;
    if (res_vld !== exp_vld || (exp_vld && {res_cout, res_sum} !== exp_v)) begin
      bad++;
      $display("FAIL %s: actual vld=%0b val=%h expected vld=%0b val=%h",
               tag, res_vld, {res_cout, res_sum}, exp_vld, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog expired: actual cycles=%0d expected <=5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W:0] held;
    repeat (3) @(negedge clk);
    // R6: reset state
    check_res("R6 reset state", '0, 1'b0);
    rst = 1'b0;

    // R1 R3 R4 R5: back-to-back stream of the table
    for (int i = 0; i < N + 2; i++) begin
      if (i >= 2) check_res($sformatf("R1 R3 vector %0d", i - 2), ripple(VA[i-2], VB[i-2]), 1'b1);
      if (i < N) begin
        op_vld = 1'b1; op_a = VA[i]; op_b = VB[i];
      end else begin
        op_vld = 1'b0; op_a = '1; op_b = '1;
      end
      @(negedge clk);
    end
    // R4 R5 explicit corner values
    total++;
    if (ripple(VA[2], VB[2]) !== {1'b0, 100'h4_0000_0000_0000}) begin
      bad++; $display("FAIL R4 reference: actual %h expected 2^50", ripple(VA[2], VB[2]));
    end

    // R7: idle with garbage operands, output holds last result
    held = ripple(VA[N-1], VB[N-1]);
    for (int j = 0; j < 4; j++) begin
      op_a = {25{4'hC}} ^ W'(j); op_b = {25{4'h3}};
      @(negedge clk);
      total++;
      if (res_vld !== 1'b0 || {res_cout, res_sum} !== held) begin
        bad++;
        $display("FAIL R7 hold: actual vld=%0b val=%h expected vld=0 val=%h",
                 res_vld, {res_cout, res_sum}, held);
      end
    end

    // R2: single strobe with gap, valid exactly two edges later
    op_vld = 1'b1; op_a = 100'h3_FFFF_FFFF_FFFF; op_b = 100'h3_FFFF_FFFF_FFFF;
    @(negedge clk);
    op_vld = 1'b0; op_a = '0; op_b = '0;
    check_res("R2 one edge after strobe", held, 1'b0);
    @(negedge clk);
    check_res("R2 R4 two edges after strobe",
              ripple(100'h3_FFFF_FFFF_FFFF, 100'h3_FFFF_FFFF_FFFF), 1'b1);
    @(negedge clk);
    check_res("R2 three edges after strobe",
              ripple(100'h3_FFFF_FFFF_FFFF, 100'h3_FFFF_FFFF_FFFF), 1'b0);

    // R6: reset while a pair is in flight
    op_vld = 1'b1; op_a = {W{1'b1}}; op_b = 100'd5;
    @(negedge clk);
    op_vld = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check_res("R6 reset clears output", '0, 1'b0);
    total++;
    if ({res_cout, res_sum} !== '0) begin
      bad++; $display("FAIL R6 value: actual %h expected 0", {res_cout, res_sum});
    end
    rst = 1'b0;
    @(negedge clk);
    check_res("R6 in-flight pair discarded", '0, 1'b0);
    @(negedge clk);
    check_res("R6 still idle", '0, 1'b0);
    total++;
    if ({res_cout, res_sum} !== '0) begin
      bad++; $display("FAIL R6 discard: actual %h expected 0", {res_cout, res_sum});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule